// File: doc/BRIEF.md
# Serial IRQ Host Controller

This block is the host end of a single shared, open-drain interrupt wire used by low-pin-count peripherals. The host pulls the wire low to mark the start of a cycle. It then walks a fixed train of three-clock data frames, one per interrupt slot. A peripheral that wants to raise an interrupt pulls the wire low during the first clock of its slot. After the last frame the host drives a stop pulse whose length tells the peripherals which mode comes next. The states captured during a cycle are published as parallel interrupt outputs. Each output has its own polarity select, so a consumer can take each line as active high or active low.

The cycle is shaped by a set of control inputs: a global enable, a mode bit (the host starts every cycle, or a cycle starts only when a peripheral asks), a 4-bit frame-count field and a 2-bit start-width field. The wire is modelled as a sampled input `serirqIn` and a pull-down enable `serirqOe`. The pad outside the block ties these together with a pull-up. Slot `i` drives `irqOut[i]`. Slots 0 and 1 carry the two lowest interrupt lines, and slot 2 carries the system-management request.

Top module: `sirq_host`

## Requirements
- R1: While `ctrlEnable` is 0, `serirqOe` is 0 from the next clock on, any cycle in progress is abandoned, the captured states are cleared and every `irqOut[i]` equals `irqPolarity[i]` (inactive).
- R2: With enable set and `ctrlQuiet` = 0, the host begins a new cycle after exactly one idle clock following the end of the previous cycle.
- R3: With enable set and `ctrlQuiet` = 1, the host never starts a cycle while the wire reads high in the idle state.
- R4: A cycle holds 17 + `ctrlFrames` data frames of three clocks each. The first frame begins two clocks after the start pulse ends. Slot `f` is asserted when `serirqIn` is 0 on the first clock of frame `f`.
- R5: A host-begun start pulse drives the wire low for 4 clocks when `ctrlPulse` = 00, 6 clocks for 01, 8 clocks for 10 and 4 clocks for the reserved code 11.
- R6: After reset the block is idle with `serirqOe` = 0 and every output inactive.
- R7: In quiet mode, a one-clock low on the idle wire starts a cycle, and the host continues the low for the programmed width minus one clock.
- R8: `irqOut[i]` is the captured state of slot `i` XOR `irqPolarity[i]`, so polarity 0 is active high and 1 is active low.
- R9: The stop pulse drives the wire low for 2 clocks in quiet mode or 3 clocks in continuous mode. It is followed by two released clocks before the block is idle.
- R10: Captured states change only on the last clock of a cycle, so outputs hold steady while frames are sampled. Slots at or beyond the frame count stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrlEnable | input | 1 | Enables all serial interrupt activity |
| ctrlQuiet | input | 1 | 0 = continuous, 1 = quiet (peripheral-started) |
| ctrlFrames | input | 4 | Frame count minus 17 |
| ctrlPulse | input | 2 | Start pulse width select (00=4, 01=6, 10=8, 11=4) |
| irqPolarity | input | 32 | Per-slot output polarity, 1 = active low |
| serirqIn | input | 1 | Sampled level of the shared wire |
| serirqOe | output | 1 | Host pull-down enable for the shared wire |
| irqOut | output | 32 | Decoded interrupt outputs, one per slot |

## Verification
A behavioural timeline model predicts the pull-down and every output on each clock. It is run through continuous cycles at every start-width code, including the reserved one. Runs use the shortest and the longest frame count, with slots asserted at the first, last and an out-of-range position. These runs separate the start width, the frame spacing and the stop length. A mid-cycle disable shows whether the cycle is abandoned and the outputs cleared. Quiet-mode runs with and without a peripheral request separate the start detection and pulse extension from continuous starts. Mixed polarity masks check the XOR per slot, and a mid-cycle output check shows whether updates wait for the end of the cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int FRAME_FIELD_W = 4;
  localparam int BASE_FRAMES   = 17;
  localparam int MAX_FRAMES    = BASE_FRAMES + (1 << FRAME_FIELD_W) - 1;
  localparam int IDX_W         = $clog2(MAX_FRAMES);
  localparam int CNT_W         = 4;
  localparam int MAX_PULSE     = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_SREC, ST_STURN, ST_DATA, ST_STOP, ST_PREC, ST_PTURN
  } seqState_t;

  typedef struct packed {
    logic             sampleEn;
    logic [IDX_W-1:0] slot;
    logic             clearAll;
    logic             commit;
  } seqStrobe_t;
endpackage

// File: rtl/sirq_sequencer.sv
module sirq_sequencer
  import sirq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     quiet,
  input  logic [FRAME_FIELD_W-1:0] frameSel,
  input  logic [1:0]               pulseSel,
  input  logic                     lineIn,
  output logic                     lineDrive,
  output seqStrobe_t               strobe,
  output seqState_t                seqState
);
  seqState_t        st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] frm;
  logic [CNT_W-1:0] pulseLast;
  logic [CNT_W-1:0] stopLast;
  logic [IDX_W-1:0] lastFrame;

  always_comb begin
    case (pulseSel)
      2'b01:   pulseLast = CNT_W'(5);
      2'b10:   pulseLast = CNT_W'(7);
      default: pulseLast = CNT_W'(3);
    endcase
    stopLast  = quiet ? CNT_W'(1) : CNT_W'(2);
    lastFrame = IDX_W'(BASE_FRAMES - 1) + IDX_W'(frameSel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      frm <= '0;
    end else if (!enable) begin
      st  <= ST_IDLE;
      cnt <= '0;
      frm <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!quiet) begin
            st  <= ST_START;
            cnt <= '0;
          end else if (!lineIn) begin
            // peripheral already supplied the first low clock
            st  <= ST_START;
            cnt <= CNT_W'(1);
          end
        end
        ST_START: begin
          if (cnt >= pulseLast) st <= ST_SREC;
          else cnt <= cnt + 1'b1;
        end
        ST_SREC:  st <= ST_STURN;
        ST_STURN: begin
          st  <= ST_DATA;
          cnt <= '0;
          frm <= '0;
        end
        ST_DATA: begin
          if (cnt == CNT_W'(2)) begin
            cnt <= '0;
            if (frm == lastFrame) st <= ST_STOP;
            else frm <= frm + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == stopLast) begin
            st  <= ST_PREC;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PREC:  st <= ST_PTURN;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lineDrive       = (st == ST_START) || (st == ST_STOP);
    strobe.sampleEn = (st == ST_DATA) && (cnt == '0);
    strobe.slot     = frm;
    strobe.clearAll = (st == ST_SREC);
    strobe.commit   = (st == ST_PTURN);
    seqState        = st;
  end
endmodule

// File: rtl/sirq_slots.sv
module sirq_slots
  import sirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  lineIn,
  input  seqStrobe_t            strobe,
  input  logic [MAX_FRAMES-1:0] polarity,
  output logic [MAX_FRAMES-1:0] irqState,
  output logic [MAX_FRAMES-1:0] irqOut
);
  logic [MAX_FRAMES-1:0] samples;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samples  <= '0;
      irqState <= '0;
    end else if (!enable) begin
      samples  <= '0;
      irqState <= '0;
    end else begin
      if (strobe.clearAll) samples <= '0;
      if (strobe.sampleEn && !lineIn) samples[strobe.slot] <= 1'b1;
      if (strobe.commit) irqState <= samples;
    end
  end

  assign irqOut = (enable ? irqState : '0) ^ polarity;
endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrlEnable,
  input  logic                     ctrlQuiet,
  input  logic [FRAME_FIELD_W-1:0] ctrlFrames,
  input  logic [1:0]               ctrlPulse,
  input  logic [MAX_FRAMES-1:0]    irqPolarity,
  input  logic                     serirqIn,
  output logic                     serirqOe,
  output logic [MAX_FRAMES-1:0]    irqOut
);
  seqStrobe_t            strobe;
  seqState_t             seqState;
  logic [MAX_FRAMES-1:0] irqState;

  sirq_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .enable(ctrlEnable), .quiet(ctrlQuiet),
    .frameSel(ctrlFrames), .pulseSel(ctrlPulse), .lineIn(serirqIn),
    .lineDrive(serirqOe), .strobe(strobe), .seqState(seqState)
  );

  sirq_slots u_slots (
    .clk(clk), .rst_n(rst_n), .enable(ctrlEnable), .lineIn(serirqIn),
    .strobe(strobe), .polarity(irqPolarity),
    .irqState(irqState), .irqOut(irqOut)
  );
endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk
  import sirq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ctrlEnable,
  input logic                  ctrlQuiet,
  input logic                  serirqIn,
  input logic                  serirqOe,
  input logic                  sampleEn,
  input logic                  commit,
  input seqState_t             seqState,
  input logic [MAX_FRAMES-1:0] irqState
);
  logic [CNT_W-1:0] oeRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oeRun <= '0;
    else if (!serirqOe) oeRun <= '0;
    else if (oeRun != '1) oeRun <= oeRun + 1'b1;
  end

  assert_release_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEnable |=> !serirqOe);

  assert_clear_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEnable |=> (irqState == '0));

  assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEnable && ctrlQuiet && seqState == ST_IDLE && serirqIn) |=> !serirqOe);

  assert_no_drive_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sampleEn |-> !serirqOe);

  assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oeRun <= CNT_W'(MAX_PULSE));

  assert_hold_midcycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEnable && !commit) |=> $stable(irqState));
endmodule

bind sirq_host sirq_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrlEnable(ctrlEnable), .ctrlQuiet(ctrlQuiet),
  .serirqIn(serirqIn), .serirqOe(serirqOe),
  .sampleEn(strobe.sampleEn), .commit(strobe.commit),
  .seqState(seqState), .irqState(irqState)
);

// File: tb/sim_sirq_host.sv
module sim_sirq_host;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic        quiet = 0;
  logic [3:0]  frames = 0;
  logic [1:0]  pulse = 0;
  logic [31:0] pol = 0;
  logic        periphLow = 0;
  logic        oe;
  logic        lineIn;
  logic [31:0] irqOut;

  int          checks = 0;
  int          fails = 0;
  int          t = -1;
  logic [31:0] samp = 0;
  logic [31:0] expIrq = 0;
  logic [31:0] slotMask = 0;
  bit          reqPending = 0;

  assign lineIn = ~(oe | periphLow);

  always #5 clk = ~clk;

  sirq_host u0 (
    .clk(clk), .rst_n(rst_n), .ctrlEnable(en), .ctrlQuiet(quiet),
    .ctrlFrames(frames), .ctrlPulse(pulse), .irqPolarity(pol),
    .serirqIn(lineIn), .serirqOe(oe), .irqOut(irqOut)
  );

  function automatic int pw(logic [1:0] p);
    if (p == 2'b01) return 6;
    if (p == 2'b10) return 8;
    return 4;
  endfunction

  function automatic bit expOeAt(int tt);
    int w, d, l;
    w = pw(pulse);
    d = w + 2 + 3 * (17 + int'(frames));
    l = quiet ? 2 : 3;
    return (tt >= 0) && ((tt < w) || (tt >= d && tt < d + l));
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h t=%0d @%0t", tag, act, exp, t, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #6;
  endtask

  // reference timeline model, advanced on each rising edge and compared after it
  always @(posedge clk) begin
    int w, d, total;
    bit lineLow;
    string tag;
    logic [31:0] expOut;
    w = pw(pulse);
    d = w + 2 + 3 * (17 + int'(frames));
    total = d + (quiet ? 2 : 3) + 2;
    lineLow = expOeAt(t) || periphLow;
    if (!rst_n || !en) begin
      t = -1; samp = 0; expIrq = 0;
    end else if (t < 0) begin
      if (!quiet) begin t = 0; samp = 0; end
      else if (lineLow) begin t = 1; samp = 0; end
    end else begin
      if (t >= w + 2 && t < d && (t - w - 2) % 3 == 0 && lineLow)
        samp[(t - w - 2) / 3] = 1'b1;
      if (t == total - 1) begin expIrq = samp; t = -1; end
      else t++;
    end
    #3;
    if (!rst_n) tag = "R6";
    else if (!en) tag = "R1";
    else if (t < 0) tag = quiet ? "R3" : "R2";
    else if (t < w) tag = quiet ? "R7" : "R5";
    else if (t >= d) tag = "R9";
    else tag = "R4";
    chk(oe == expOeAt(t), tag, {31'd0, oe}, {31'd0, expOeAt(t)});
    expOut = (en ? expIrq : 32'd0) ^ pol;
    chk(irqOut == expOut, (!rst_n ? "R6" : (!en ? "R1" : "R8")), irqOut, expOut);
  end

  // peripheral: requests quiet starts and pulls its slots low
  always @(negedge clk) begin
    int w, d;
    w = pw(pulse);
    d = w + 2 + 3 * (17 + int'(frames));
    periphLow = 0;
    if (rst_n && en) begin
      if (t < 0) begin
        if (quiet && reqPending) begin periphLow = 1; reqPending = 0; end
      end else if (t >= w + 2 && t < d && (t - w - 2) % 3 == 0 && slotMask[(t - w - 2) / 3])
        periphLow = 1;
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    chk(oe == 1'b0 && irqOut == 32'd0, "R6", irqOut, 32'd0);
    rst_n = 1;
    step(2);

    // continuous, 17 frames, 4-clock start; slot 20 is out of range
    slotMask = 32'h0011_0007;
    en = 1;
    step(200);
    chk(irqOut[16] == 1'b1, "R4", irqOut, 32'h0001_0007);
    chk(irqOut[20] == 1'b0, "R10", irqOut, 32'h0001_0007);
    chk(irqOut[2:0] == 3'b111, "R8", irqOut, 32'h0001_0007);

    // disable mid-cycle
    step(20);
    en = 0;
    step(3);
    chk(oe == 1'b0 && irqOut == pol, "R1", irqOut, pol);

    // 32 frames, 6-clock start, mixed polarity
    frames = 4'hF; pulse = 2'b01; pol = 32'h0000_0005;
    slotMask = 32'h8000_0020;
    en = 1;
    step(40);
    chk(irqOut == pol, "R10", irqOut, pol);
    step(260);
    chk(irqOut == (32'h8000_0020 ^ pol), "R8", irqOut, 32'h8000_0020 ^ pol);

    // 8-clock start, then reserved code
    en = 0; step(2);
    frames = 4'h2; pulse = 2'b10; slotMask = 32'h0000_0102;
    en = 1; step(180);
    en = 0; step(2);
    pulse = 2'b11; slotMask = 32'h0000_0040;
    en = 1; step(160);
    chk(irqOut == (32'h0000_0040 ^ pol), "R5", irqOut, 32'h0000_0040 ^ pol);

    // quiet mode: no request, then requests
    en = 0; step(2);
    quiet = 1; frames = 4'h3; pulse = 2'b10; pol = 32'hFFFF_0000;
    slotMask = 32'h0008_0001;
    en = 1; step(50);
    chk(oe == 1'b0 && irqOut == pol, "R3", irqOut, pol);
    reqPending = 1; step(120);
    chk(irqOut == (32'h0008_0001 ^ pol), "R7", irqOut, 32'h0008_0001 ^ pol);
    en = 0; step(2);
    pulse = 2'b00; slotMask = 32'h0000_0004;
    en = 1; reqPending = 1; step(120);
    chk(irqOut == (32'h0000_0004 ^ pol), "R9", irqOut, 32'h0000_0004 ^ pol);
    step(10);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule